// File: doc/BRIEF.md
# SD Command and Response Engine

This block issues a single SD/MMC command frame on the CMD line and captures the card's reply. The host presents an 8-bit command index byte and a 32-bit argument. It also presents a header length, a response length and three per-command options, then pulses `go`. The engine shifts out the start, transmission, index and argument bits, follows them with a CRC7 it computes itself, and ends the frame with a stop bit. It then releases the line and waits a bounded time for the card's start bit.

After the start bit, the engine captures the programmed number of response bits and checks the response CRC7. The check starts either at the start bit or at bit 8 for long (136-bit) replies, and an option skips the check. Another option holds completion until the card releases DAT0 from busy. At completion a sticky interrupt flag is raised together with status bits: CRC match, response timeout and overall command good. The captured response is read as four 32-bit words, with index 0 holding the most significant word. One bit is moved per clock, so the block is clocked from the card-clock enable domain. A soft reset aborts any command in flight.

Top module: `sdcmd_engine`

## Requirements
- R1: After `go` is accepted in idle, `cmd_out` carries bits 39 down to 39-N of `{cmd_index, cmd_arg}`, one per clock and MSB first, where N is `hdr_len` limited to 39. An index byte of 0x40 OR a 6-bit opcode therefore starts the frame with 0 then 1.
- R2: After the header come 7 CRC bits, MSB first, of polynomial x^7+x^3+1 computed over the header bits with the register starting at zero, then a single 1. `cmd_oe` is high for exactly these N+9 clocks, and `cmd_out` idles at 1.
- R3: With `resp_len` M non-zero, the engine captures a reply of M+3 bits starting at the first 0 seen on `cmd_in`. With M equal to 0 it completes at the end of the frame without listening.
- R4: `resp_word` at `rd_idx` i returns captured bits, counted from the start bit as bit 0, at positions T-9-32*(3-i)-31 through T-9-32*(3-i), the first of these being the MSB, where T is the reply length. Positions below 0 read as 0 and the capture is cleared at each accepted `go`. For a 48-bit reply, word 3 is the 32-bit payload and word 0 is zero.
- R5: `crc_ok` is 1 after completion exactly when the CRC7 over the covered reply bits equals reply bits T-8..T-2. The covered bits run from bit 0 up to bit T-9.
- R6: With `crc_from8` set, the covered range starts at reply bit 8 instead of bit 0.
- R7: `cmd_ok` is 1 at completion when no timeout occurred and one of these holds: `crc_ok` is 1, `skip_crc` is set, or M is 0.
- R8: With `wait_busy` set, completion is held after the reply (or after the frame when M is 0) until `dat0_in` is sampled high.
- R9: If no 0 is sampled on `cmd_in` during the first 64 listening clocks, the engine completes with `resp_timeout` 1 and `cmd_ok` 0. A start bit sampled on the 64th listening clock is accepted.
- R10: `done_irq` rises on the clock where `busy` falls at completion and stays high until `irq_clr` is sampled high. When completion and `irq_clr` fall in the same clock, the flag is set.
- R11: `busy` is 1 from the clock after `go` is accepted until completion. `go` while busy has no effect on the command in flight and starts no further command.
- R12: `soft_rst` sampled high returns the engine to idle on the next clock. The in-flight frame is aborted, `cmd_oe` drops and `done_irq` and the status bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Abort and return to idle |
| go | input | 1 | Start a command (accepted in idle) |
| cmd_arg | input | 32 | Command argument |
| cmd_index | input | 8 | Command index byte (0x40 OR opcode) |
| hdr_len | input | 6 | Header bits minus one (normally 39) |
| resp_len | input | 8 | Reply bits between start and end bit, minus one; 0 = no reply |
| skip_crc | input | 1 | Treat reply as good regardless of CRC |
| crc_from8 | input | 1 | Start reply CRC check at bit 8 |
| wait_busy | input | 1 | Wait for DAT0 release before completion |
| cmd_in | input | 1 | Sampled CMD line |
| dat0_in | input | 1 | Sampled DAT0 line |
| irq_clr | input | 1 | Write-1-clear of `done_irq` |
| rd_idx | input | 2 | Response word select, 0 = most significant |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| busy | output | 1 | Command in progress |
| done_irq | output | 1 | Sticky command-done interrupt |
| crc_ok | output | 1 | Reply CRC7 matched |
| resp_timeout | output | 1 | No reply start bit in time |
| cmd_ok | output | 1 | Command completed good |
| resp_word | output | 32 | Selected response word |

## Verification
The completion event that sets `done_irq` can meet a host write-1-clear on the same clock. The bench provokes this by holding `irq_clr` high for the whole of a command, so the clear is sampled on the completion edge. It judges that the flag is high just after that edge and low one clock later, when only the clear remains. A second overlap is a `go` arriving while a frame is being shifted. That case is judged by the transmitted frame staying bit-exact and by no second command starting.

// File: rtl/sdcmd_pkg.sv
// Shared types and constants for the SD command engine.
// Assumes: one CMD bit per clock; CRC7 taps fixed by the SD standard.
package sdcmd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX,
        ST_RXWAIT,
        ST_RX,
        ST_BUSYW
    } sdcmd_state_e;

    localparam int          CRC_W     = 7;
    localparam logic [6:0]  CRC7_TAPS = 7'h09;
endpackage

// File: rtl/sdcmd_crc7.sv
// Serial CRC generator/checker, MSB-first.
// Assumes: clr has priority over en; feeding din = crc[MSB] shifts the
// remainder out unchanged, which the transmitter uses to emit it.
module sdcmd_crc7 #(
    parameter int           W    = 7,
    parameter logic [W-1:0] TAPS = 7'h09
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc
);
    logic fb;
    assign fb = crc[W-1] ^ din;

    // Clear or advance the remainder by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= {crc[W-2:0], 1'b0} ^ (fb ? TAPS : '0);
        end
    end
endmodule

// File: rtl/sdcmd_resp_store.sv
// Response capture shift register with word read-out.
// Assumes: CAP_W = TAIL_W + WORD_W*NWORDS; the newest bit enters at bit 0,
// the lowest TAIL_W bits hold the received CRC after the last shift.
module sdcmd_resp_store #(
    parameter int CAP_W  = 135,
    parameter int WORD_W = 32,
    parameter int NWORDS = 4,
    parameter int TAIL_W = 7,
    parameter int SEL_W  = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              din,
    input  logic [SEL_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] word,
    output logic [TAIL_W-1:0] tail
);
    logic [CAP_W-1:0]  cap;
    logic [WORD_W-1:0] words [NWORDS];

    // Clear at command start, shift one reply bit per enabled clock.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cap <= '0;
        end else if (shift_en) begin
            cap <= {cap[CAP_W-2:0], din};
        end
    end

    // Word 0 is the most significant slice above the CRC tail.
    for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
        assign words[gi] = cap[TAIL_W + WORD_W*(NWORDS-1-gi) +: WORD_W];
    end

    assign word = words[rd_idx];
    assign tail = cap[TAIL_W-1:0];
endmodule

// File: rtl/sdcmd_engine.sv
// SD/MMC command frame transmitter and response receiver.
// Sends header + CRC7 + end bit, listens for a reply start bit within a
// bounded window, captures the reply, checks its CRC7, optionally waits
// for DAT0 release, then raises a sticky completion flag with status.
// Assumes: one bit per clk (clk is the card-clock enable domain);
// cmd_in and dat0_in are already synchronised.
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int ARG_W     = 32,
    parameter int IDX_W     = 8,
    parameter int LEN_W     = 6,
    parameter int RLEN_W    = 8,
    parameter int RESP_MAX  = 136,
    parameter int WORD_W    = 32,
    parameter int RSP_WAIT  = 64,
    parameter int LONG_SKIP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              go,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [LEN_W-1:0]  hdr_len,
    input  logic [RLEN_W-1:0] resp_len,
    input  logic              skip_crc,
    input  logic              crc_from8,
    input  logic              wait_busy,
    input  logic              cmd_in,
    input  logic              dat0_in,
    input  logic              irq_clr,
    input  logic [1:0]        rd_idx,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic              busy,
    output logic              done_irq,
    output logic              crc_ok,
    output logic              resp_timeout,
    output logic              cmd_ok,
    output logic [WORD_W-1:0] resp_word
);
    localparam int HDR_W  = IDX_W + ARG_W;
    localparam int TXC_W  = $clog2(HDR_W + 9) + 1;
    localparam int RXC_W  = RLEN_W + 1;
    localparam int WT_W   = $clog2(RSP_WAIT) + 1;
    localparam int CAP_W  = RESP_MAX - 1;
    localparam int NWORDS = (CAP_W - CRC_W) / WORD_W;

    sdcmd_state_e      state_q;
    logic [HDR_W-1:0]  hdr_q;
    logic [TXC_W-1:0]  hdr_last_q, tx_cnt, hl_ext, hdr_last_d;
    logic [RLEN_W-1:0] resp_len_q;
    logic              skip_q, from8_q, wbusy_q;
    logic [RXC_W-1:0]  rx_cnt, rx_k, start_pos;
    logic [WT_W-1:0]   wt_cnt;
    logic [CRC_W-1:0]  crc_q, tail;
    logic              go_take, tx_in_hdr, tx_in_crc, tx_last, tx_bit;
    logic              start_seen, rx_last, rx_crc_en, cap_shift;
    logic              crc_clr, crc_en, crc_din, crc_match_now;
    logic              timeout_evt, done_evt, ok_now;

    // Header length is limited to the bits actually held.
    assign hl_ext     = TXC_W'(hdr_len);
    assign hdr_last_d = (hl_ext > TXC_W'(HDR_W-1)) ? TXC_W'(HDR_W-1) : hl_ext;

    // Transmit phase decode: header, CRC, end bit.
    assign go_take   = (state_q == ST_IDLE) && go && !soft_rst;
    assign tx_in_hdr = tx_cnt <= hdr_last_q;
    assign tx_in_crc = !tx_in_hdr && (tx_cnt <= hdr_last_q + TXC_W'(7));
    assign tx_last   = tx_cnt == hdr_last_q + TXC_W'(8);
    assign tx_bit    = tx_in_hdr ? hdr_q[HDR_W-1] : (tx_in_crc ? crc_q[CRC_W-1] : 1'b1);

    // Receive phase decode: bit index k counts from the start bit.
    assign start_seen = (state_q == ST_RXWAIT) && !cmd_in;
    assign rx_k       = (state_q == ST_RXWAIT) ? '0 : rx_cnt;
    assign start_pos  = from8_q ? RXC_W'(LONG_SKIP) : '0;
    assign rx_last    = (state_q == ST_RX) && (rx_cnt == RXC_W'(resp_len_q) + RXC_W'(2));
    assign rx_crc_en  = (start_seen || state_q == ST_RX) && (rx_k >= start_pos)
                        && (rx_k + RXC_W'(6) <= RXC_W'(resp_len_q));
    assign cap_shift  = start_seen || ((state_q == ST_RX) && !rx_last);

    // One CRC unit serves both directions; it is cleared between them.
    assign crc_clr = go_take || soft_rst || ((state_q == ST_TX) && tx_last);
    assign crc_en  = ((state_q == ST_TX) && (tx_in_hdr || tx_in_crc)) || rx_crc_en;
    assign crc_din = (state_q == ST_TX) ? tx_bit : cmd_in;
    assign crc_match_now = crc_q == tail;

    // Completion sources.
    assign timeout_evt = (state_q == ST_RXWAIT) && cmd_in && (wt_cnt == WT_W'(RSP_WAIT-1));
    assign done_evt = ((state_q == ST_TX) && tx_last && resp_len_q == '0 && !wbusy_q)
                   || timeout_evt
                   || (rx_last && !wbusy_q)
                   || ((state_q == ST_BUSYW) && dat0_in);
    assign ok_now = (resp_len_q == '0) || skip_q
                 || ((state_q == ST_RX) ? crc_match_now : crc_ok);

    sdcmd_crc7 #(.W(CRC_W), .TAPS(CRC7_TAPS)) u_crc (
        .clk (clk), .rst_n (rst_n), .clr (crc_clr), .en (crc_en),
        .din (crc_din), .crc (crc_q)
    );

    sdcmd_resp_store #(.CAP_W(CAP_W), .WORD_W(WORD_W), .NWORDS(NWORDS), .TAIL_W(CRC_W)) u_store (
        .clk (clk), .rst_n (rst_n), .clr (go_take), .shift_en (cap_shift),
        .din (cmd_in), .rd_idx (rd_idx), .word (resp_word), .tail (tail)
    );

    // Sequencer: latch the command, walk TX, listen, receive, busy wait.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state_q    <= ST_IDLE;
            hdr_q      <= '0;
            hdr_last_q <= '0;
            resp_len_q <= '0;
            skip_q     <= 1'b0;
            from8_q    <= 1'b0;
            wbusy_q    <= 1'b0;
            tx_cnt     <= '0;
            rx_cnt     <= '0;
            wt_cnt     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (go) begin
                    state_q    <= ST_TX;
                    hdr_q      <= {cmd_index, cmd_arg};
                    hdr_last_q <= hdr_last_d;
                    resp_len_q <= resp_len;
                    skip_q     <= skip_crc;
                    from8_q    <= crc_from8;
                    wbusy_q    <= wait_busy;
                    tx_cnt     <= '0;
                end
                ST_TX: begin
                    hdr_q  <= hdr_q << 1;
                    tx_cnt <= tx_cnt + TXC_W'(1);
                    if (tx_last) begin
                        wt_cnt <= '0;
                        if (resp_len_q != '0) state_q <= ST_RXWAIT;
                        else if (wbusy_q)     state_q <= ST_BUSYW;
                        else                  state_q <= ST_IDLE;
                    end
                end
                ST_RXWAIT: begin
                    if (!cmd_in) begin
                        state_q <= ST_RX;
                        rx_cnt  <= RXC_W'(1);
                    end else if (timeout_evt) begin
                        state_q <= ST_IDLE;
                    end else begin
                        wt_cnt <= wt_cnt + WT_W'(1);
                    end
                end
                ST_RX: begin
                    if (rx_last) state_q <= wbusy_q ? ST_BUSYW : ST_IDLE;
                    else         rx_cnt  <= rx_cnt + RXC_W'(1);
                end
                ST_BUSYW: if (dat0_in) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Status and sticky completion flag; completion beats write-1-clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            crc_ok       <= 1'b0;
            resp_timeout <= 1'b0;
            cmd_ok       <= 1'b0;
            done_irq     <= 1'b0;
        end else begin
            if (go_take) begin
                crc_ok       <= 1'b0;
                resp_timeout <= 1'b0;
                cmd_ok       <= 1'b0;
            end
            if (rx_last)     crc_ok       <= crc_match_now;
            if (timeout_evt) resp_timeout <= 1'b1;
            if (done_evt)    cmd_ok       <= !timeout_evt && ok_now;
            if (done_evt)     done_irq <= 1'b1;
            else if (irq_clr) done_irq <= 1'b0;
        end
    end

    assign busy    = state_q != ST_IDLE;
    assign cmd_oe  = state_q == ST_TX;
    assign cmd_out = (state_q == ST_TX) ? tx_bit : 1'b1;

    // Completion flag only rises together with the end of a command.
    assert_irq_rise_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_irq) |-> $fell(busy));
    // Flag holds until a clear or soft reset is sampled.
    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_irq && !irq_clr && !soft_rst) |=> done_irq);
    // A timed-out command never reports good.
    assert_timeout_not_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_timeout |-> !cmd_ok);
    // Listening window counter never passes its limit.
    assert_wait_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RXWAIT) |-> (wt_cnt < WT_W'(RSP_WAIT)));
    // Soft reset leaves the engine idle and quiet.
    assert_soft_rst_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy && !cmd_oe && !done_irq));
    // DAT0 held low keeps the command open.
    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_BUSYW) && !dat0_in && !soft_rst) |=> busy);
    // A go while busy does not reload the command.
    assert_go_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !soft_rst) |=> ($stable(resp_len_q) && $stable(skip_q) && $stable(hdr_last_q)));
endmodule

// File: tb/sdcmd_engine_tb.sv
module sdcmd_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0, go = 1'b0;
    logic [31:0] cmd_arg = '0;
    logic [7:0]  cmd_index = '0;
    logic [5:0]  hdr_len = 6'd39;
    logic [7:0]  resp_len = '0;
    logic        skip_crc = 1'b0, crc_from8 = 1'b0, wait_busy = 1'b0;
    logic        cmd_in = 1'b1, dat0_in = 1'b1, irq_clr = 1'b0;
    logic [1:0]  rd_idx = '0;
    logic        cmd_out, cmd_oe, busy, done_irq, crc_ok, resp_timeout, cmd_ok;
    logic [31:0] resp_word;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sdcmd_engine u_dut (
        .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst), .go (go),
        .cmd_arg (cmd_arg), .cmd_index (cmd_index), .hdr_len (hdr_len),
        .resp_len (resp_len), .skip_crc (skip_crc), .crc_from8 (crc_from8),
        .wait_busy (wait_busy), .cmd_in (cmd_in), .dat0_in (dat0_in),
        .irq_clr (irq_clr), .rd_idx (rd_idx), .cmd_out (cmd_out),
        .cmd_oe (cmd_oe), .busy (busy), .done_irq (done_irq), .crc_ok (crc_ok),
        .resp_timeout (resp_timeout), .cmd_ok (cmd_ok), .resp_word (resp_word)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] crc_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = c[6] ^ b;
        crc_step = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

    function automatic logic [6:0] crc_range(input logic [255:0] v, input int lo, input int hi);
        logic [6:0] c = '0;
        for (int k = lo; k <= hi; k++) c = crc_step(c, v[k]);
        return c;
    endfunction

    // Reply bit k at index k; k = 0 is the start bit.
    function automatic logic [255:0] build_short(input logic [5:0] op, input logic [31:0] pl, input bit bad);
        logic [255:0] rb = '0;
        logic [6:0]   c;
        rb[1] = 1'b0;
        for (int k = 0; k < 6; k++)  rb[2+k] = op[5-k];
        for (int k = 0; k < 32; k++) rb[8+k] = pl[31-k];
        c = crc_range(rb, 0, 39);
        if (bad) c[0] = ~c[0];
        for (int k = 0; k < 7; k++) rb[40+k] = c[6-k];
        rb[47] = 1'b1;
        return rb;
    endfunction

    function automatic logic [255:0] build_long();
        logic [255:0] rb = '0;
        logic [6:0]   c;
        for (int k = 2; k < 8; k++)   rb[k] = 1'b1;
        for (int k = 8; k < 128; k++) rb[k] = ((k * 7 + 3) % 5) < 2;
        c = crc_range(rb, 8, 127);
        for (int k = 0; k < 7; k++) rb[128+k] = c[6-k];
        rb[135] = 1'b1;
        return rb;
    endfunction

    function automatic logic [31:0] exp_word(input logic [255:0] rb, input int total, input int i);
        logic [31:0] w = '0;
        for (int b = 0; b < 32; b++) begin
            int kk;
            kk = total - 9 - 32*(3-i) - b;
            w[b] = (kk >= 0) ? rb[kk] : 1'b0;
        end
        return w;
    endfunction

    task automatic chk_frame(input string req, input logic [7:0] idx, input logic [31:0] arg,
                             input int hl, input int nbits, input logic [127:0] got);
        logic [39:0]  hdr;
        logic [127:0] exp = '0;
        logic [6:0]   c = '0;
        int           n = 0;
        hdr = {idx, arg};
        for (int k = 0; k <= hl; k++) begin
            exp[n] = hdr[39-k];
            c = crc_step(c, hdr[39-k]);
            n++;
        end
        for (int j = 6; j >= 0; j--) begin
            exp[n] = c[j];
            n++;
        end
        exp[n] = 1'b1;
        n++;
        check_eq(req, "frame length", 64'(nbits), 64'(n));
        check_eq(req, "frame bits low", got[63:0], exp[63:0]);
        check_eq(req, "frame bits high", got[127:64], exp[127:64]);
    endtask

    // Issue a command and record the frame; returns on the first negedge
    // after the frame (first listening cycle if a reply is expected).
    task automatic send_cmd(input logic [7:0] idx, input logic [31:0] arg, input int hl,
                            input logic [7:0] rl, input bit sk, input bit f8, input bit wb,
                            input int poke_at, input int abort_at,
                            output int nbits, output logic [127:0] got);
        cmd_index = idx; cmd_arg = arg; hdr_len = 6'(hl); resp_len = rl;
        skip_crc = sk; crc_from8 = f8; wait_busy = wb;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check_eq("R11", "busy after go", 64'(busy), 64'd1);
        nbits = 0;
        got = '0;
        while (cmd_oe && nbits < 128) begin
            got[nbits] = cmd_out;
            if (nbits == poke_at) begin
                go = 1'b1;
                cmd_index = idx ^ 8'h3F;
            end
            if (nbits == abort_at) soft_rst = 1'b1;
            nbits++;
            @(negedge clk);
            go = 1'b0;
            soft_rst = 1'b0;
        end
    endtask

    task automatic card_reply(input logic [255:0] rb, input int total, input int delay);
        repeat (delay) @(negedge clk);
        for (int k = 0; k < total; k++) begin
            cmd_in = rb[k];
            @(negedge clk);
        end
        cmd_in = 1'b1;
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check_eq("R10", "irq cleared by write-1", 64'(done_irq), 64'd0);
    endtask

    task automatic t_reset();
        check_eq("R11", "busy at reset", 64'(busy), 64'd0);
        check_eq("R2", "oe at reset", 64'(cmd_oe), 64'd0);
        check_eq("R2", "idle line high", 64'(cmd_out), 64'd1);
        check_eq("R10", "irq at reset", 64'(done_irq), 64'd0);
    endtask

    task automatic t_no_reply();
        int nb; logic [127:0] g;
        send_cmd(8'h40, 32'h0, 39, 8'd0, 0, 0, 0, -1, -1, nb, g);
        chk_frame("R2", 8'h40, 32'h0, 39, nb, g);
        check_eq("R1", "first two bits 0,1", {62'd0, g[1], g[0]}, 64'h2);
        check_eq("R3", "done with no reply", {62'd0, done_irq, busy}, 64'h2);
        check_eq("R7", "ok with no reply", 64'(cmd_ok), 64'd1);
        clear_irq();
    endtask

    task automatic t_short_reply();
        int nb; logic [127:0] g; logic [255:0] rb;
        send_cmd(8'h51, 32'h1234_5678, 39, 8'd45, 0, 0, 0, -1, -1, nb, g);
        chk_frame("R1", 8'h51, 32'h1234_5678, 39, nb, g);
        rb = build_short(6'h11, 32'hCAFE_F00D, 0);
        card_reply(rb, 48, 3);
        check_eq("R3", "done after reply", {62'd0, done_irq, busy}, 64'h2);
        check_eq("R5", "crc ok good reply", 64'(crc_ok), 64'd1);
        check_eq("R7", "cmd ok good reply", 64'(cmd_ok), 64'd1);
        check_eq("R9", "no timeout", 64'(resp_timeout), 64'd0);
        rd_idx = 2'd3; #1;
        check_eq("R4", "word 3 payload", 64'(resp_word), 64'(exp_word(rb, 48, 3)));
        rd_idx = 2'd0; #1;
        check_eq("R4", "word 0 empty", 64'(resp_word), 64'd0);
        clear_irq();
    endtask

    task automatic t_bad_crc();
        int nb; logic [127:0] g; logic [255:0] rb;
        rb = build_short(6'h0D, 32'h0000_0900, 1);
        send_cmd(8'h4D, 32'h0001_0000, 39, 8'd45, 0, 0, 0, -1, -1, nb, g);
        card_reply(rb, 48, 0);
        check_eq("R5", "crc bad detected", 64'(crc_ok), 64'd0);
        check_eq("R7", "cmd not ok on bad crc", 64'(cmd_ok), 64'd0);
        clear_irq();
        send_cmd(8'h4D, 32'h0001_0000, 39, 8'd45, 1, 0, 0, -1, -1, nb, g);
        card_reply(rb, 48, 1);
        check_eq("R7", "skip flag: crc still bad", 64'(crc_ok), 64'd0);
        check_eq("R7", "skip flag: cmd ok", 64'(cmd_ok), 64'd1);
        clear_irq();
    endtask

    task automatic t_long_reply();
        int nb; logic [127:0] g; logic [255:0] rb; logic [6:0] cf; logic [6:0] rx;
        rb = build_long();
        send_cmd(8'h42, 32'h0, 39, 8'd133, 0, 1, 0, -1, -1, nb, g);
        card_reply(rb, 136, 2);
        check_eq("R6", "crc from bit 8 ok", 64'(crc_ok), 64'd1);
        for (int i = 0; i < 4; i++) begin
            rd_idx = 2'(i); #1;
            check_eq("R4", $sformatf("long word %0d", i), 64'(resp_word), 64'(exp_word(rb, 136, i)));
        end
        clear_irq();
        cf = crc_range(rb, 0, 127);
        for (int k = 0; k < 7; k++) rx[6-k] = rb[128+k];
        send_cmd(8'h42, 32'h0, 39, 8'd133, 0, 0, 0, -1, -1, nb, g);
        card_reply(rb, 136, 2);
        check_eq("R6", "crc from bit 0 on long reply", 64'(crc_ok), 64'(cf == rx));
        clear_irq();
    endtask

    task automatic t_busy_wait();
        int nb; logic [127:0] g; logic [255:0] rb;
        rb = build_short(6'h07, 32'h0000_0700, 0);
        dat0_in = 1'b0;
        send_cmd(8'h47, 32'h0, 39, 8'd45, 0, 0, 1, -1, -1, nb, g);
        card_reply(rb, 48, 1);
        check_eq("R8", "held after reply", {62'd0, done_irq, busy}, 64'h1);
        repeat (10) @(negedge clk);
        check_eq("R8", "still held while DAT0 low", {62'd0, done_irq, busy}, 64'h1);
        dat0_in = 1'b1;
        @(negedge clk);
        check_eq("R8", "done after DAT0 release", {62'd0, done_irq, busy}, 64'h2);
        check_eq("R7", "ok after busy wait", 64'(cmd_ok), 64'd1);
        clear_irq();
    endtask

    task automatic t_timeout();
        int nb; logic [127:0] g; logic [255:0] rb;
        rb = build_short(6'h03, 32'hA5A5_0000, 0);
        send_cmd(8'h43, 32'h0, 39, 8'd45, 0, 0, 0, -1, -1, nb, g);
        card_reply(rb, 48, 63);
        check_eq("R9", "start on last window clock", {62'd0, resp_timeout, crc_ok}, 64'h1);
        clear_irq();
        send_cmd(8'h43, 32'h0, 39, 8'd45, 0, 0, 0, -1, -1, nb, g);
        repeat (63) @(negedge clk);
        check_eq("R9", "still listening at 63", 64'(busy), 64'd1);
        @(negedge clk);
        check_eq("R9", "timeout completion", {61'd0, done_irq, resp_timeout, busy}, 64'h6);
        check_eq("R9", "timeout not ok", 64'(cmd_ok), 64'd0);
        clear_irq();
    endtask

    task automatic t_short_header();
        int nb; logic [127:0] g;
        send_cmd(8'h5A, 32'hFFFF_1234, 15, 8'd0, 0, 0, 0, -1, -1, nb, g);
        chk_frame("R1", 8'h5A, 32'hFFFF_1234, 15, nb, g);
        clear_irq();
    endtask

    task automatic t_irq_collide();
        int nb; logic [127:0] g;
        irq_clr = 1'b1;
        send_cmd(8'h40, 32'h0, 39, 8'd0, 0, 0, 0, -1, -1, nb, g);
        check_eq("R10", "set wins over clear", 64'(done_irq), 64'd1);
        @(negedge clk);
        irq_clr = 1'b0;
        check_eq("R10", "clear next clock", 64'(done_irq), 64'd0);
    endtask

    task automatic t_go_while_busy();
        int nb; logic [127:0] g;
        send_cmd(8'h48, 32'h0000_01AA, 39, 8'd0, 0, 0, 0, 5, -1, nb, g);
        chk_frame("R11", 8'h48, 32'h0000_01AA, 39, nb, g);
        @(negedge clk);
        check_eq("R11", "no second command", 64'(busy), 64'd0);
        clear_irq();
    endtask

    task automatic t_soft_reset();
        int nb; logic [127:0] g;
        send_cmd(8'h51, 32'h0, 39, 8'd45, 0, 0, 0, -1, 10, nb, g);
        check_eq("R12", "abort bit count", 64'(nb), 64'd11);
        check_eq("R12", "idle after abort", {61'd0, busy, cmd_oe, done_irq}, 64'h0);
        check_eq("R12", "line high after abort", 64'(cmd_out), 64'd1);
        repeat (70) @(negedge clk);
        check_eq("R12", "no completion after abort", 64'(done_irq), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_reply();
        t_short_reply();
        t_bad_crc();
        t_long_reply();
        t_busy_wait();
        t_timeout();
        t_short_header();
        t_irq_collide();
        t_go_while_busy();
        t_soft_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule